// File: doc/BRIEF.md
# PC Card Attribute Configuration Registers

This block is the attribute-memory side of a PC Card / CompactFlash ATA card. The host reaches it over a byte-wide attribute bus with an address, a read strobe, a write strobe and write/read data. Addresses below a configurable base are served from an external card information ROM, and addresses that also lie past the ROM length read as zero. From the base upward sit four byte registers at even offsets: the option register, the card status register, the pin register and the socket register.

The block also merges three things into one host interrupt line: the level of the drive's interrupt request, captured into the status register, the two gating bits of the ATA device control register, and the soft-reset bit of the option register. Writing a reset bit through either the option register or the device control port clears the card state and raises a one-cycle soft-reset pulse toward the drive. The drive itself and the ROM contents lie outside this block.

Top module: `card_attr_cfg`

## Requirements
- R1: A read at an address below BASE returns `rom_data` for `rom_addr` (the low address bits) when the address is below ROM_LEN, and returns 0x00 when it is not.
- R2: The option register sits at BASE+0, status at BASE+2, pin at BASE+4 and socket at BASE+6. Any other address at or above BASE reads 0x00, and so does the socket register. Read data appears one cycle after the read strobe and holds while no read is made.
- R3: An option write with bit 7 clear stores the written byte ANDed with 0xCF. Bits 5:0 are the addressing mode and bit 6 selects level interrupts.
- R4: An option write with bit 7 set is a soft reset. The option register becomes 0x80, the status register is cleared except bit 1, card-ready is cleared, both device control bits are cleared, and `soft_rst` is high for exactly the following cycle.
- R5: A status write keeps the current bits under 0x82 and loads the written bits under 0x74.
- R6: A status write whose bit 2 (power-down) differs from the stored bit 2 sets card-ready (pin bit 5). A status write that leaves bit 2 unchanged does not.
- R7: A status read returns the stored byte, but with bit 1 forced to 0 while the device control interrupt-disable bit is set.
- R8: A pin read returns 0x0C ORed with card-ready in bit 5. A pin write never changes card-ready.
- R9: `host_irq` is high only when status bit 1 is 0, both device control bits are 0 and option bit 7 is 0.
- R10: Status bit 1 takes the value of `drv_irq` on every clock edge. This includes edges with a status write and edges with a soft reset.
- R11: A device control write stores `dctl_nien` and `dctl_srst`. With `dctl_srst` set, it also clears the option register, the status register (except bit 1) and card-ready, and pulses `soft_rst` for one cycle.
- R12: A write to the socket register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attr_addr | input | ADDR_W | Attribute space byte address |
| attr_rd | input | 1 | Read strobe |
| attr_wr | input | 1 | Write strobe |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Registered read data |
| rom_addr | output | ROM_AW | Card information ROM address |
| rom_data | input | 8 | ROM byte for `rom_addr`, same cycle |
| drv_irq | input | 1 | Drive interrupt request level |
| dctl_wr | input | 1 | Device control register write strobe |
| dctl_nien | input | 1 | Device control interrupt-disable bit |
| dctl_srst | input | 1 | Device control soft-reset bit |
| host_irq | output | 1 | Host interrupt line (inverted sense of status bit 1) |
| soft_rst | output | 1 | One-cycle soft-reset pulse to the drive |

## Verification
The drive interrupt input updates status bit 1 on every edge, so it can coincide with a host status write or with a soft reset. The bench raises `drv_irq` on the same edge as a status write of 0x00, and again on the same edge as an option write with bit 7 set. In both cases a later status read must show bit 1 set, the other bits must follow the write or reset rules, and `host_irq` must be low.

// File: rtl/card_attr_pkg.sv
package card_attr_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROM,
    SEL_OPT,
    SEL_STAT,
    SEL_PIN,
    SEL_SOCK
  } attr_sel_e;

  // option register
  localparam logic [DW-1:0] OPT_WMASK   = 8'hCF;
  localparam int            OPT_SRST_B  = 7;

  // status register
  localparam logic [DW-1:0] STAT_KEEP   = 8'h82;
  localparam logic [DW-1:0] STAT_LOAD   = 8'h74;
  localparam int            STAT_IRQ_B  = 1;
  localparam int            STAT_PWR_B  = 2;

  // pin register
  localparam logic [DW-1:0] PIN_FIXED   = 8'h0C;
  localparam int            PIN_RDY_B   = 5;

endpackage

// File: rtl/card_attr_decode.sv
module card_attr_decode
  import card_attr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BASE    = 'h200,
  parameter int ROM_LEN = 'h14A,
  localparam int ROM_AW = $clog2(ROM_LEN)
) (
  input  logic [ADDR_W-1:0] addr,
  output attr_sel_e         sel,
  output logic [ROM_AW-1:0] rom_addr
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] ROM_END = ADDR_W'(ROM_LEN);

  logic [ADDR_W-1:0] off;
  assign off      = addr - BASE_A;
  assign rom_addr = addr[ROM_AW-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (addr < BASE_A) begin
      if (addr < ROM_END) sel = SEL_ROM;
    end else if (off[ADDR_W-1:3] == '0 && !off[0]) begin
      case (off[2:1])
        2'd0:    sel = SEL_OPT;
        2'd1:    sel = SEL_STAT;
        2'd2:    sel = SEL_PIN;
        default: sel = SEL_SOCK;
      endcase
    end
  end

endmodule

// File: rtl/card_attr_state.sv
module card_attr_state
  import card_attr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  attr_sel_e     sel,
  input  logic [DW-1:0] wdata,
  input  logic          drv_irq,
  input  logic          dctl_wr,
  input  logic          dctl_nien,
  input  logic          dctl_srst,
  output logic [DW-1:0] opt_q,
  output logic [DW-1:0] stat_q,
  output logic          card_rdy,
  output logic          nien_q,
  output logic          dsrst_q,
  output logic          srst_pulse
);

  logic [DW-1:0] opt_d, stat_d;
  logic          rdy_d, nien_d, dsrst_d;
  logic          srst_opt, srst_ctl, srst_any;

  assign srst_opt = wr && (sel == SEL_OPT) && wdata[OPT_SRST_B];
  assign srst_ctl = dctl_wr && dctl_srst;
  assign srst_any = srst_opt || srst_ctl;

  always_comb begin
    opt_d   = opt_q;
    stat_d  = stat_q;
    rdy_d   = card_rdy;
    nien_d  = nien_q;
    dsrst_d = dsrst_q;
    if (srst_any) begin
      opt_d   = srst_opt ? (DW'(1) << OPT_SRST_B) : '0;
      stat_d  = '0;
      rdy_d   = 1'b0;
      nien_d  = dctl_wr ? dctl_nien : 1'b0;
      dsrst_d = dctl_wr ? dctl_srst : 1'b0;
    end else begin
      if (wr) begin
        case (sel)
          SEL_OPT:  opt_d = wdata & OPT_WMASK;
          SEL_STAT: begin
            if (stat_q[STAT_PWR_B] != wdata[STAT_PWR_B]) rdy_d = 1'b1;
            stat_d = (stat_q & STAT_KEEP) | (wdata & STAT_LOAD);
          end
          default: ;
        endcase
      end
      if (dctl_wr) begin
        nien_d  = dctl_nien;
        dsrst_d = dctl_srst;
      end
    end
    stat_d[STAT_IRQ_B] = drv_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q      <= '0;
      stat_q     <= '0;
      card_rdy   <= 1'b0;
      nien_q     <= 1'b0;
      dsrst_q    <= 1'b0;
      srst_pulse <= 1'b0;
    end else begin
      opt_q      <= opt_d;
      stat_q     <= stat_d;
      card_rdy   <= rdy_d;
      nien_q     <= nien_d;
      dsrst_q    <= dsrst_d;
      srst_pulse <= srst_any;
    end
  end

endmodule

// File: rtl/card_attr_rdata.sv
module card_attr_rdata
  import card_attr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  attr_sel_e     sel,
  input  logic [DW-1:0] rom_data,
  input  logic [DW-1:0] opt_q,
  input  logic [DW-1:0] stat_q,
  input  logic          card_rdy,
  input  logic          hide_irq,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] stat_view, pin_view, rd_val;

  always_comb begin
    stat_view = stat_q;
    if (hide_irq) stat_view[STAT_IRQ_B] = 1'b0;
    pin_view = PIN_FIXED;
    pin_view[PIN_RDY_B] = card_rdy;
    case (sel)
      SEL_ROM:  rd_val = rom_data;
      SEL_OPT:  rd_val = opt_q;
      SEL_STAT: rd_val = stat_view;
      SEL_PIN:  rd_val = pin_view;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end

endmodule

// File: rtl/card_attr_cfg.sv
module card_attr_cfg
  import card_attr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BASE    = 'h200,
  parameter int ROM_LEN = 'h14A,
  localparam int ROM_AW = $clog2(ROM_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] attr_addr,
  input  logic              attr_rd,
  input  logic              attr_wr,
  input  logic [7:0]        attr_wdata,
  output logic [7:0]        attr_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  input  logic              drv_irq,
  input  logic              dctl_wr,
  input  logic              dctl_nien,
  input  logic              dctl_srst,
  output logic              host_irq,
  output logic              soft_rst
);

  attr_sel_e     sel;
  logic [DW-1:0] opt_q, stat_q;
  logic          card_rdy, nien_q, dsrst_q;

  card_attr_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .ROM_LEN(ROM_LEN)
  ) u_decode (
    .addr(attr_addr), .sel(sel), .rom_addr(rom_addr)
  );

  card_attr_state u_state (
    .clk(clk), .rst(rst), .wr(attr_wr), .sel(sel), .wdata(attr_wdata),
    .drv_irq(drv_irq), .dctl_wr(dctl_wr), .dctl_nien(dctl_nien),
    .dctl_srst(dctl_srst), .opt_q(opt_q), .stat_q(stat_q),
    .card_rdy(card_rdy), .nien_q(nien_q), .dsrst_q(dsrst_q),
    .srst_pulse(soft_rst)
  );

  card_attr_rdata u_rdata (
    .clk(clk), .rst(rst), .rd(attr_rd), .sel(sel), .rom_data(rom_data),
    .opt_q(opt_q), .stat_q(stat_q), .card_rdy(card_rdy),
    .hide_irq(nien_q), .rdata(attr_rdata)
  );

  // inverted sense: line high while no interrupt is latched and nothing gates it
  assign host_irq = !stat_q[STAT_IRQ_B] && !nien_q && !dsrst_q && !opt_q[OPT_SRST_B];

endmodule

// File: rtl/card_attr_cfg_chk.sv
module card_attr_cfg_chk
  import card_attr_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          attr_wr,
  input logic          attr_rd,
  input attr_sel_e     sel,
  input logic [DW-1:0] attr_wdata,
  input logic [DW-1:0] attr_rdata,
  input logic          dctl_wr,
  input logic          dctl_srst,
  input logic          drv_irq,
  input logic          host_irq,
  input logic          soft_rst,
  input logic [DW-1:0] opt_q,
  input logic [DW-1:0] stat_q,
  input logic          card_rdy
);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !attr_rd |=> $stable(attr_rdata));

  p_opt_srst_r4: assert property (@(posedge clk) disable iff (rst)
    (attr_wr && sel == SEL_OPT && attr_wdata[OPT_SRST_B])
      |=> (soft_rst && opt_q == 8'h80 && !card_rdy));

  p_pwr_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (attr_wr && sel == SEL_STAT && !(dctl_wr && dctl_srst) &&
     (attr_wdata[STAT_PWR_B] != stat_q[STAT_PWR_B])) |=> card_rdy);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    drv_irq |=> !host_irq);

  p_irq_track_r10: assert property (@(posedge clk) disable iff (rst)
    drv_irq |=> stat_q[STAT_IRQ_B]);

  p_ctl_srst_r11: assert property (@(posedge clk) disable iff (rst)
    (dctl_wr && dctl_srst) |=> (soft_rst && !host_irq && opt_q == 8'h00));

  p_sock_r12: assert property (@(posedge clk) disable iff (rst)
    (attr_wr && sel == SEL_SOCK && !dctl_wr) |=> ($stable(opt_q) && $stable(card_rdy)));

endmodule

bind card_attr_cfg card_attr_cfg_chk u_chk (
  .clk(clk), .rst(rst), .attr_wr(attr_wr), .attr_rd(attr_rd), .sel(sel),
  .attr_wdata(attr_wdata), .attr_rdata(attr_rdata), .dctl_wr(dctl_wr),
  .dctl_srst(dctl_srst), .drv_irq(drv_irq), .host_irq(host_irq),
  .soft_rst(soft_rst), .opt_q(opt_q), .stat_q(stat_q), .card_rdy(card_rdy)
);

// File: tb/card_attr_cfg_bench.sv
module card_attr_cfg_bench;

  localparam int ADDR_W  = 12;
  localparam int BASE    = 'h200;
  localparam int ROM_LEN = 'h14A;
  localparam int ROM_AW  = $clog2(ROM_LEN);

  localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + 2);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(BASE + 4);
  localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(BASE + 6);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] attr_addr = '0;
  logic              attr_rd = 1'b0, attr_wr = 1'b0;
  logic [7:0]        attr_wdata = '0;
  logic [7:0]        attr_rdata;
  logic [ROM_AW-1:0] rom_addr;
  logic [7:0]        rom_data;
  logic              drv_irq = 1'b0;
  logic              dctl_wr = 1'b0, dctl_nien = 1'b0, dctl_srst = 1'b0;
  logic              host_irq, soft_rst;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
    return (a[7:0] * 8'd7 + 8'd3) ^ {7'd0, a[8]};
  endfunction

  assign rom_data = rom_byte(rom_addr);

  card_attr_cfg #(.ADDR_W(ADDR_W), .BASE(BASE), .ROM_LEN(ROM_LEN)) u_card_attr_cfg (
    .clk(clk), .rst(rst), .attr_addr(attr_addr), .attr_rd(attr_rd),
    .attr_wr(attr_wr), .attr_wdata(attr_wdata), .attr_rdata(attr_rdata),
    .rom_addr(rom_addr), .rom_data(rom_data), .drv_irq(drv_irq),
    .dctl_wr(dctl_wr), .dctl_nien(dctl_nien), .dctl_srst(dctl_srst),
    .host_irq(host_irq), .soft_rst(soft_rst)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_attr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    attr_addr = a; attr_wdata = d; attr_wr = 1'b1;
    @(negedge clk);
    attr_wr = 1'b0;
  endtask

  task automatic rd_attr(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    attr_addr = a; attr_rd = 1'b1;
    @(negedge clk);
    attr_rd = 1'b0;
    d = attr_rdata;
  endtask

  task automatic wr_dctl(input logic nien, input logic srst);
    @(negedge clk);
    dctl_wr = 1'b1; dctl_nien = nien; dctl_srst = srst;
    @(negedge clk);
    dctl_wr = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_attr(a, v);
    check(tag, v, exp);
  endtask

  task automatic clean_state();
    wr_dctl(1'b0, 1'b1);
    wr_dctl(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R9 reset host_irq", {7'd0, host_irq}, 8'h01);
    check("R4 reset soft_rst", {7'd0, soft_rst}, 8'h00);
    expect_reg("R3 reset option", A_OPT, 8'h00);
    expect_reg("R5 reset status", A_STAT, 8'h00);
    expect_reg("R8 reset pin", A_PIN, 8'h0C);
  endtask

  task automatic t_rom();
    expect_reg("R1 rom low", 12'h010, rom_byte(9'h010));
    expect_reg("R1 rom last", 12'h149, rom_byte(9'h149));
    expect_reg("R1 past rom", 12'h14A, 8'h00);
    expect_reg("R1 below base", 12'h1FF, 8'h00);
  endtask

  task automatic t_map();
    expect_reg("R2 odd offset", 12'h201, 8'h00);
    expect_reg("R2 unused offset", 12'h20A, 8'h00);
    expect_reg("R2 top address", 12'hFFF, 8'h00);
    expect_reg("R2 socket read", A_SOCK, 8'h00);
  endtask

  task automatic t_option();
    wr_attr(A_OPT, 8'h7F); expect_reg("R3 mask 0x7F", A_OPT, 8'h4F);
    wr_attr(A_OPT, 8'h30); expect_reg("R3 mask 0x30", A_OPT, 8'h00);
    wr_attr(A_OPT, 8'h4A); expect_reg("R3 mode+level", A_OPT, 8'h4A);
    check("R4 no pulse on plain write", {7'd0, soft_rst}, 8'h00);
  endtask

  task automatic t_opt_reset();
    wr_attr(A_STAT, 8'h74);
    wr_dctl(1'b1, 1'b0);
    wr_attr(A_OPT, 8'h41);
    wr_attr(A_OPT, 8'hC5);
    check("R4 pulse high", {7'd0, soft_rst}, 8'h01);
    @(negedge clk);
    check("R4 pulse one cycle", {7'd0, soft_rst}, 8'h00);
    expect_reg("R4 option after reset", A_OPT, 8'h80);
    expect_reg("R4 status after reset", A_STAT, 8'h00);
    expect_reg("R4 pin after reset", A_PIN, 8'h0C);
    check("R9 gated by option bit7", {7'd0, host_irq}, 8'h00);
    wr_attr(A_OPT, 8'h00);
    check("R4 control cleared", {7'd0, host_irq}, 8'h01);
  endtask

  task automatic t_status();
    clean_state();
    wr_attr(A_STAT, 8'h70);
    expect_reg("R5 load 0x70", A_STAT, 8'h70);
    expect_reg("R6 no power change", A_PIN, 8'h0C);
    wr_attr(A_STAT, 8'h8F);
    expect_reg("R5 merge 0x8F", A_STAT, 8'h04);
    expect_reg("R6 power toggle", A_PIN, 8'h2C);
  endtask

  task automatic t_pin();
    wr_attr(A_PIN, 8'h00);
    expect_reg("R8 ready kept", A_PIN, 8'h2C);
    clean_state();
    wr_attr(A_PIN, 8'hFF);
    expect_reg("R8 write cannot set ready", A_PIN, 8'h0C);
  endtask

  task automatic t_irq();
    clean_state();
    @(negedge clk); drv_irq = 1'b1;
    @(negedge clk);
    check("R10 drive irq low host", {7'd0, host_irq}, 8'h00);
    expect_reg("R10 status bit1", A_STAT, 8'h02);
    wr_dctl(1'b1, 1'b0);
    expect_reg("R7 bit1 hidden", A_STAT, 8'h00);
    @(negedge clk); drv_irq = 1'b0;
    @(negedge clk);
    check("R9 gated by disable", {7'd0, host_irq}, 8'h00);
    wr_dctl(1'b0, 1'b0);
    check("R9 ungated", {7'd0, host_irq}, 8'h01);
  endtask

  task automatic t_ctl_reset();
    wr_attr(A_OPT, 8'h41);
    wr_attr(A_STAT, 8'h74);
    wr_dctl(1'b0, 1'b1);
    check("R11 pulse", {7'd0, soft_rst}, 8'h01);
    check("R11 host gated", {7'd0, host_irq}, 8'h00);
    expect_reg("R11 option cleared", A_OPT, 8'h00);
    expect_reg("R11 status cleared", A_STAT, 8'h00);
    expect_reg("R11 pin cleared", A_PIN, 8'h0C);
    wr_dctl(1'b0, 1'b0);
    check("R11 released", {7'd0, host_irq}, 8'h01);
  endtask

  task automatic t_socket();
    wr_attr(A_OPT, 8'h4A);
    wr_attr(A_STAT, 8'h70);
    wr_attr(A_SOCK, 8'hFF);
    expect_reg("R12 option kept", A_OPT, 8'h4A);
    expect_reg("R12 status kept", A_STAT, 8'h70);
    expect_reg("R12 pin kept", A_PIN, 8'h0C);
    expect_reg("R12 socket reads 0", A_SOCK, 8'h00);
    check("R12 irq kept", {7'd0, host_irq}, 8'h01);
  endtask

  task automatic t_same_cycle();
    clean_state();
    @(negedge clk);
    attr_addr = A_STAT; attr_wdata = 8'h00; attr_wr = 1'b1; drv_irq = 1'b1;
    @(negedge clk);
    attr_wr = 1'b0;
    expect_reg("R10 irq beats status write", A_STAT, 8'h02);
    check("R9 host low", {7'd0, host_irq}, 8'h00);
    wr_attr(A_OPT, 8'h80);
    expect_reg("R10 irq survives soft reset", A_STAT, 8'h02);
    @(negedge clk); drv_irq = 1'b0;
    expect_reg("R10 irq drops", A_STAT, 8'h00);
    wr_attr(A_OPT, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rom();
    t_map();
    t_option();
    t_opt_reset();
    t_status();
    t_pin();
    t_irq();
    t_ctl_reset();
    t_socket();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule